// File: doc/BRIEF.md
# Stop Mode Power-Down Controller

This block holds one 8-bit control and status register and a four-state sequencer. When the processor issues a stop request, the sequencer picks one of three low-power states: a shallow stop that keeps all state, a partial power-down that keeps its state in retention, or a full power-down that loses it. Two control bits choose the state. Software may write them once after reset or after a power-down wake. Later writes leave them unchanged.

A wake event returns the sequencer to run. A wake from either power-down depth sets a sticky flag for that depth and clears the control bits and the write lock. A wake from full power-down also clears the other flag, because it acts as a reset. Software clears both flags by writing 1 to a write-only acknowledge bit.

The states are `ST_RUN`, `ST_SHALLOW`, `ST_PD_FULL` and `ST_PD_PART`. The transitions are:

- **go_shallow**: run to shallow, on a stop request with power-down disabled.
- **go_full**: run to full, on a stop request with power-down enabled and depth 0.
- **go_part**: run to partial, on a stop request with power-down enabled and depth 1.
- **wake_shallow**, **wake_full** and **wake_part**: back to run, on a wake event.

Top module: `stop_pwr_ctrl`

## Requirements
- R1: After reset the register reads 0x00, the sequencer is in run and every mode output is low.
- R2: Read data bits 7, 6, 5 and bit 2 (the acknowledge bit) always read 0.
- R3: In run, the first register write after reset or after a power-down wake loads bit 1 (power-down enable) and bit 0 (depth) and sets the lock. A write and a stop request in the same cycle use the old control values.
- R4: While the lock is set, writes leave bits 1 and 0 unchanged.
- R5: A stop request in run with bit 1 = 0 enters shallow stop: `shallow_o` and `retain_o` are high. The following wake leaves flags and control bits unchanged.
- R6: A stop request with bit 1 = 1 and bit 0 = 0 enters full power-down: `pd_full_o` is high and `retain_o` is low. The wake sets bit 4, clears bit 3 and clears the control bits and the lock.
- R7: A stop request with bit 1 = 1 and bit 0 = 1 enters partial power-down: `pd_part_o` and `retain_o` are high. The wake sets bit 3, keeps bit 4 and clears the control bits and the lock.
- R8: Writing 1 to bit 2 in run clears bits 4 and 3. Writing 0 to bit 2 leaves them unchanged.
- R9: At most one of the three mode outputs is high. All three are low in run. While stopped, register writes and stop requests have no effect.
- R10: A wake event in run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DW | Register write data |
| rd_data | output | DW | Register read value |
| stop_req | input | 1 | Stop request from the processor |
| wake_evt | input | 1 | Wake event |
| shallow_o | output | 1 | Shallow stop active |
| pd_full_o | output | 1 | Full power-down active |
| pd_part_o | output | 1 | Partial power-down active |
| retain_o | output | 1 | Keep the state retention supply on |

## Verification
The bench builds the block with the default DW = 8, so the three unimplemented bits are visible at the port. Random sequences of writes, acknowledges, stop requests and wake events drive the block, and a bench model tracks the lock, both flags and the state. This brings within reach the lock being re-armed after each power-down wake, several wakes stacking up flags, and same-cycle combinations such as a write together with a stop request.

// File: rtl/stop_pwr_pkg.sv
package stop_pwr_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_SHALLOW = 2'd1,
        ST_PD_FULL = 2'd2,
        ST_PD_PART = 2'd3
    } pm_state_t;

    localparam int BIT_FULL_F = 4;
    localparam int BIT_PART_F = 3;
    localparam int BIT_ACK    = 2;
    localparam int BIT_EN     = 1;
    localparam int BIT_DEPTH  = 0;
endpackage

// File: rtl/spm_ctrl_bits.sv
module spm_ctrl_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ok,
    input  logic wd_en,
    input  logic wd_depth,
    input  logic clr,
    output logic pd_en,
    output logic depth,
    output logic locked
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_en  <= 1'b0;
            depth  <= 1'b0;
            locked <= 1'b0;
        end else if (clr) begin
            pd_en  <= 1'b0;
            depth  <= 1'b0;
            locked <= 1'b0;
        end else if (wr_ok && !locked) begin
            pd_en  <= wd_en;
            depth  <= wd_depth;
            locked <= 1'b1;
        end
    end

    // R4: once locked, control bits hold until a power-down wake clears them
    a_r4_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !clr) |=> ($stable(pd_en) && $stable(depth) && locked));

    // R3: the first accepted write sets the lock
    a_r3_first_write_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && !locked && !clr) |=> locked);
endmodule

// File: rtl/spm_flags.sv
module spm_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    input  logic wake_full,
    input  logic wake_part,
    output logic full_f,
    output logic part_f
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_f <= 1'b0;
            part_f <= 1'b0;
        end else if (wake_full) begin
            full_f <= 1'b1;
            part_f <= 1'b0;
        end else if (wake_part) begin
            part_f <= 1'b1;
        end else if (ack) begin
            full_f <= 1'b0;
            part_f <= 1'b0;
        end
    end

    a_r6_full_wake_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wake_full |=> (full_f && !part_f));

    a_r7_part_wake_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wake_part |=> (part_f && full_f == $past(full_f)));

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wake_full && !wake_part) |=> (!full_f && !part_f));
endmodule

// File: rtl/spm_seq.sv
module spm_seq
    import stop_pwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stop_req,
    input  logic      wake_evt,
    input  logic      pd_en,
    input  logic      depth,
    output pm_state_t state,
    output logic      wake_full,
    output logic      wake_part,
    output logic      shallow_o,
    output logic      pd_full_o,
    output logic      pd_part_o,
    output logic      retain_o
);
    pm_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (stop_req) begin
                    if (!pd_en)     nxt = ST_SHALLOW;  // go_shallow
                    else if (depth) nxt = ST_PD_PART;  // go_part
                    else            nxt = ST_PD_FULL;  // go_full
                end
            end
            ST_SHALLOW: if (wake_evt) nxt = ST_RUN;    // wake_shallow
            ST_PD_FULL: if (wake_evt) nxt = ST_RUN;    // wake_full
            ST_PD_PART: if (wake_evt) nxt = ST_RUN;    // wake_part
            default:    nxt = ST_RUN;
        endcase
    end

    always_comb begin
        shallow_o = 1'b0;
        pd_full_o = 1'b0;
        pd_part_o = 1'b0;
        retain_o  = 1'b0;
        wake_full = 1'b0;
        wake_part = 1'b0;
        unique case (state)
            ST_RUN: ;
            ST_SHALLOW: begin
                shallow_o = 1'b1;
                retain_o  = 1'b1;
            end
            ST_PD_FULL: begin
                pd_full_o = 1'b1;
                wake_full = wake_evt;
            end
            ST_PD_PART: begin
                pd_part_o = 1'b1;
                retain_o  = 1'b1;
                wake_part = wake_evt;
            end
            default: ;
        endcase
    end

    a_r9_one_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shallow_o, pd_full_o, pd_part_o}));

    a_r5_shallow_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && stop_req && !pd_en) |=> (state == ST_SHALLOW));

    a_r10_wake_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !stop_req) |=> (state == ST_RUN));
endmodule

// File: rtl/stop_pwr_ctrl.sv
module stop_pwr_ctrl
    import stop_pwr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic          stop_req,
    input  logic          wake_evt,
    output logic          shallow_o,
    output logic          pd_full_o,
    output logic          pd_part_o,
    output logic          retain_o
);
    pm_state_t state;
    logic wake_full, wake_part, wr_ok;
    logic pd_en, depth, locked, full_f, part_f;
    logic unused_wd;

    assign wr_ok     = wr_en && (state == ST_RUN);
    assign unused_wd = ^wr_data;

    spm_seq u_seq (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wake_evt(wake_evt),
        .pd_en(pd_en), .depth(depth), .state(state),
        .wake_full(wake_full), .wake_part(wake_part),
        .shallow_o(shallow_o), .pd_full_o(pd_full_o),
        .pd_part_o(pd_part_o), .retain_o(retain_o)
    );

    spm_ctrl_bits u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok),
        .wd_en(wr_data[BIT_EN]), .wd_depth(wr_data[BIT_DEPTH]),
        .clr(wake_full || wake_part),
        .pd_en(pd_en), .depth(depth), .locked(locked)
    );

    spm_flags u_flags (
        .clk(clk), .rst_n(rst_n), .ack(wr_ok && wr_data[BIT_ACK]),
        .wake_full(wake_full), .wake_part(wake_part),
        .full_f(full_f), .part_f(part_f)
    );

    always_comb begin
        rd_data             = '0;
        rd_data[BIT_FULL_F] = full_f;
        rd_data[BIT_PART_F] = part_f;
        rd_data[BIT_EN]     = pd_en;
        rd_data[BIT_DEPTH]  = depth;
    end

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[DW-1:5] == '0) && !rd_data[BIT_ACK]);

    a_r9_stopped_writes_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN && !wake_evt) |=> $stable(rd_data));
endmodule

// File: tb/tb_stop_pwr_ctrl.sv
module tb_stop_pwr_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       stop_req = 1'b0;
    logic       wake_evt = 1'b0;
    logic       shallow_o, pd_full_o, pd_part_o, retain_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state: 0 run, 1 shallow, 2 full, 3 part
    int  m_st = 0;
    bit  m_en, m_dep, m_lock, m_pdf, m_ppdf;

    always #5 clk = ~clk;

    stop_pwr_ctrl #(.DW(8)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .stop_req(stop_req), .wake_evt(wake_evt),
        .shallow_o(shallow_o), .pd_full_o(pd_full_o),
        .pd_part_o(pd_part_o), .retain_o(retain_o)
    );

    function automatic logic [7:0] exp_rd();
        return {3'b000, m_pdf, m_ppdf, 1'b0, m_en, m_dep};
    endfunction

    function automatic logic [3:0] exp_modes();
        // {shallow, full, part, retain}
        case (m_st)
            1:       return 4'b1001;
            2:       return 4'b0100;
            3:       return 4'b0011;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        if (m_st == 0) begin
            int nst = 0;
            if (stop_req) nst = !m_en ? 1 : (m_dep ? 3 : 2);
            if (wr_en) begin
                if (!m_lock) begin
                    m_en = wr_data[1]; m_dep = wr_data[0]; m_lock = 1;
                end
                if (wr_data[2]) begin m_pdf = 0; m_ppdf = 0; end
            end
            m_st = nst;
        end else if (wake_evt) begin
            if (m_st == 2) begin m_pdf = 1; m_ppdf = 0; end
            if (m_st == 3) m_ppdf = 1;
            if (m_st != 1) begin m_en = 0; m_dep = 0; m_lock = 0; end
            m_st = 0;
        end
    endtask

    task automatic step(input bit w, input logic [7:0] d, input bit s, input bit k);
        wr_en = w; wr_data = d; stop_req = s; wake_evt = k;
        @(posedge clk);
        model_step();
        @(negedge clk);
        wr_en = 0; stop_req = 0; wake_evt = 0;
    endtask

    task automatic chk_all(input string rtag, input string mtag);
        chk(rtag, rd_data, exp_rd());
        chk(mtag, {4'b0, shallow_o, pd_full_o, pd_part_o, retain_o}, {4'b0, exp_modes()});
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(negedge clk);
        chk("R1 reset read", rd_data, 8'h00);
        chk("R1 reset modes", {4'b0, shallow_o, pd_full_o, pd_part_o, retain_o}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: wake in run does nothing
        step(0, 8'h00, 0, 1);
        chk_all("R10", "R10");
        // R3: first write; R2: ack bit and top bits read zero
        step(1, 8'hE7, 0, 0);
        chk_all("R3", "R3");
        chk("R2", {rd_data[7:5], rd_data[2]}, 4'h0);
        // R4: later write ignored
        step(1, 8'h00, 0, 0);
        chk_all("R4", "R4");
        // R7: partial power-down, writes and stop while stopped ignored (R9)
        step(0, 8'h00, 1, 0);
        chk_all("R7 entry", "R7 modes");
        step(1, 8'h04, 1, 0);
        chk_all("R9 stopped", "R9 stopped");
        step(0, 8'h00, 0, 1);
        chk_all("R7 wake", "R7 run");
        // R5: shallow stop keeps everything
        step(1, 8'h01, 0, 0);
        step(0, 8'h00, 1, 0);
        chk_all("R5 entry", "R5 modes");
        step(0, 8'h00, 0, 1);
        chk_all("R5 wake", "R5 run");
        // R8: ack with 0 no effect, ack with 1 clears
        step(1, 8'h00, 0, 0);
        chk_all("R8 zero", "R8");
        step(1, 8'h04, 0, 0);
        chk_all("R8 one", "R8");
        // R6: full power-down, re-lock after wake
        rst_n = 0; @(negedge clk); rst_n = 1;
        m_st = 0; m_en = 0; m_dep = 0; m_lock = 0; m_pdf = 0; m_ppdf = 0;
        @(negedge clk);
        step(1, 8'h03, 0, 0);
        step(0, 8'h00, 1, 0);
        step(0, 8'h00, 0, 1);
        step(1, 8'h02, 0, 0);
        step(0, 8'h00, 1, 0);
        chk_all("R6 entry", "R6 modes");
        step(0, 8'h00, 0, 1);
        chk_all("R6 wake", "R6 run");
        chk("R6 flags", rd_data & 8'h18, 8'h10);

        for (int i = 0; i < 3000; i++) begin
            bit w = ($urandom % 3) == 0;
            logic [7:0] d = 8'($urandom);
            bit s = ($urandom % 6) == 0;
            bit k = ($urandom % 4) == 0;
            if (($urandom % 4) != 0) d[2] = 1'b0;
            step(w, d, s, k);
            chk_all("R4 random", "R9 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule